// File: doc/BRIEF.md
# Duty-Cycled Supply Monitor Controller

This block sits in the always-on domain and is clocked by the slow clock. It manages an external comparator that watches a supply rail. Software sets a 4-bit threshold code, which goes straight to the comparator. It also picks a sampling mode. In that mode the comparator is off, powered all the time, or powered for a single slow-clock period once every 32, 256 or 2048 periods. Duty-cycling the comparator this way cuts its standby current.

At the end of each enabled period the controller takes the comparator's verdict. It keeps that verdict as a live status bit. A "supply below threshold" verdict counts as a detection. A detection sets a sticky flag, can raise a level interrupt, and can send a one-cycle core reset request. When it does, a second sticky flag records that the monitor caused the reset.

Software reaches the controller through a synchronous port with two registers, selected by `reg_addr`. Address 0 is the mode register. Address 1 is the status register, and reading it clears both sticky flags.

Top module: `supmon_ctrl`

## Requirements
- R1: After a synchronous reset, `mon_en`, `irq`, `core_rst_req`, `mon_thresh` and `reg_rdata` are all 0. Both registers then read back as 0.
- R2: A write to address 0 stores the threshold from bits 3:0, the sampling mode from bits 10:8, the reset enable from bit 12 and the interrupt enable from bit 13. A read of address 0 returns these fields in the same positions, with every other bit 0. `mon_thresh` always equals the stored threshold.
- R3: With sampling mode 0, or an unused code 5, 6 or 7, `mon_en` stays low. No measurement is taken, so status bit 6 keeps its value whatever the comparator does.
- R4: With sampling mode 1, `mon_en` is high on every cycle and the comparator is sampled at every clock edge.
- R5: Sampling modes 2, 3 and 4 raise `mon_en` for exactly one cycle out of every 32, 256 and 2048 cycles. The first such cycle comes 31, 255 or 2047 cycles after the mode write.
- R6: A write that changes the sampling mode restarts the period count from zero. A write that keeps the same sampling mode leaves the count running.
- R7: Status bit 6 takes `cmp_below` at the clock edge that ends an enabled cycle (1 = supply below threshold) and holds its value at all other edges.
- R8: Status bit 5 is set by any detection and cleared by a read of address 1. The read returns the value held before the clear. A detection at the same edge as the read leaves the bit set.
- R9: When mode bit 12 is set, a detection gives a one-cycle pulse on `core_rst_req` in the next cycle and sets status bit 4. Bit 4 is cleared like bit 5. With bit 12 clear, a detection gives no pulse and leaves bit 4 alone.
- R10: `irq` is high exactly when status bit 5 is set and mode bit 13 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 = mode register, 1 = status register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered, holds between reads |
| cmp_below | input | 1 | Comparator verdict, 1 = supply below threshold |
| mon_thresh | output | 4 | Threshold code to the comparator |
| mon_en | output | 1 | Comparator enable window |
| irq | output | 1 | Detection interrupt level |
| core_rst_req | output | 1 | One-cycle core reset request |

## Verification
Embedded assertions check four things on every cycle:
- a duty-cycled window never lasts more than one cycle, and the period count never exceeds its limit;
- the live status never moves between measurements;
- the sticky detection flag only falls after a status read;
- a reset pulse or interrupt is never present without its sticky flag.

The spacing of the windows, the count restart when the mode changes and the readback values around a read that lands on the same edge as a detection can only be seen in the bench scenarios. The bench runs a lockstep reference model and compares against it on every cycle.

// File: rtl/supmon_pkg.sv
// Shared field positions, codes and the mode-register layout for the supply
// monitor controller. Assumes a 32-bit register port.
package supmon_pkg;
    localparam int REG_W       = 32;
    localparam int THR_W       = 4;
    localparam int SMPL_W      = 3;
    localparam int THR_LSB     = 0;
    localparam int SMPL_LSB    = 8;
    localparam int RSTEN_BIT   = 12;
    localparam int IEN_BIT     = 13;
    localparam int ST_RST_BIT  = 4;
    localparam int ST_DET_BIT  = 5;
    localparam int ST_LIVE_BIT = 6;

    localparam logic [SMPL_W-1:0] SMPL_OFF    = 3'd0;
    localparam logic [SMPL_W-1:0] SMPL_CONT   = 3'd1;
    localparam logic [SMPL_W-1:0] SMPL_DUTY_A = 3'd2;
    localparam logic [SMPL_W-1:0] SMPL_DUTY_B = 3'd3;
    localparam logic [SMPL_W-1:0] SMPL_DUTY_C = 3'd4;

    localparam logic ADDR_MODE   = 1'b0;
    localparam logic ADDR_STATUS = 1'b1;

    typedef struct packed {
        logic              ien;
        logic              rsten;
        logic [SMPL_W-1:0] smpl;
        logic [THR_W-1:0]  thr;
    } mode_t;
endpackage

// File: rtl/supmon_regs.sv
// Register port: holds the mode register, flags sampling-mode changes,
// produces the status-clear strobe and the registered read data.
// Assumes single-cycle strobes; read data holds between reads.
module supmon_regs
    import supmon_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             rd,
    input  logic             addr,
    input  logic [REG_W-1:0] wdata,
    input  logic             st_rst,
    input  logic             st_det,
    input  logic             st_live,
    output mode_t            mode,
    output logic             smpl_chg,
    output logic             stat_clr,
    output logic [REG_W-1:0] rdata
);
    logic             mode_wr;
    logic [REG_W-1:0] mode_word;
    logic [REG_W-1:0] stat_word;

    assign mode_wr  = wr && (addr == ADDR_MODE);
    assign stat_clr = rd && (addr == ADDR_STATUS);
    assign smpl_chg = mode_wr && (wdata[SMPL_LSB +: SMPL_W] != mode.smpl);

    // Assemble the readback words from the stored fields and status flags.
    always_comb begin
        mode_word = '0;
        mode_word[THR_LSB +: THR_W]   = mode.thr;
        mode_word[SMPL_LSB +: SMPL_W] = mode.smpl;
        mode_word[RSTEN_BIT]          = mode.rsten;
        mode_word[IEN_BIT]            = mode.ien;
        stat_word = '0;
        stat_word[ST_RST_BIT]         = st_rst;
        stat_word[ST_DET_BIT]         = st_det;
        stat_word[ST_LIVE_BIT]        = st_live;
    end

    // Capture the mode fields on a write to address 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= '0;
        end else if (mode_wr) begin
            mode.thr   <= wdata[THR_LSB +: THR_W];
            mode.smpl  <= wdata[SMPL_LSB +: SMPL_W];
            mode.rsten <= wdata[RSTEN_BIT];
            mode.ien   <= wdata[IEN_BIT];
        end
    end

    // Register the read data; status is captured before its clear lands.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= (addr == ADDR_STATUS) ? stat_word : mode_word;
    end

    wire unused_wbits = ^{wdata[REG_W-1:IEN_BIT+1], wdata[SMPL_LSB+SMPL_W],
                          wdata[SMPL_LSB-1:THR_LSB+THR_W]};

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == ADDR_MODE) |=> $stable(mode));
endmodule

// File: rtl/supmon_window.sv
// Enable-window generator: off, continuous, or one cycle out of every
// PER_A/PER_B/PER_C cycles. Assumes PER_C is the largest period and every
// period is at least 2. The count restarts whenever the mode changes.
module supmon_window
    import supmon_pkg::*;
#(
    parameter int PER_A = 32,
    parameter int PER_B = 256,
    parameter int PER_C = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SMPL_W-1:0] smpl,
    input  logic              restart,
    output logic              mon_en
);
    localparam int CW = $clog2(PER_C);

    logic [CW-1:0] cnt;
    logic [CW-1:0] per_last;
    logic          duty;

    // Decode the period limit for the duty-cycled modes.
    always_comb begin
        duty     = 1'b1;
        per_last = '0;
        case (smpl)
            SMPL_DUTY_A: per_last = CW'(PER_A - 1);
            SMPL_DUTY_B: per_last = CW'(PER_B - 1);
            SMPL_DUTY_C: per_last = CW'(PER_C - 1);
            default:     duty     = 1'b0;
        endcase
    end

    // Period counter: wraps at the limit, parked at zero when not duty-cycled.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)   cnt <= '0;
        else if (!duty)          cnt <= '0;
        else if (cnt == per_last) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    assign mon_en = (smpl == SMPL_CONT) || (duty && cnt == per_last);

    // R5
    window_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty && mon_en && !restart) |=> !mon_en);
    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        duty |-> cnt <= per_last);
    // R3
    idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!duty && !restart) |=> (cnt == '0));
endmodule

// File: rtl/supmon_sampler.sv
// Measurement capture: takes the comparator verdict at the edge ending an
// enabled cycle, keeps the live and sticky flags and makes the reset pulse.
// Assumes clr is a one-cycle strobe; a new detection wins over a clear.
module supmon_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic samp,
    input  logic cmp_below,
    input  logic rsten,
    input  logic clr,
    output logic live,
    output logic st_det,
    output logic st_rst,
    output logic core_rst_req
);
    logic det;

    assign det = samp && cmp_below;

    // Live verdict: updated only at the end of an enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    live <= 1'b0;
        else if (samp) live <= cmp_below;
    end

    // Sticky flags and the one-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_det       <= 1'b0;
            st_rst       <= 1'b0;
            core_rst_req <= 1'b0;
        end else begin
            st_det       <= (st_det && !clr) || det;
            st_rst       <= (st_rst && !clr) || (det && rsten);
            core_rst_req <= det && rsten;
        end
    end

    // R7
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !samp |=> $stable(live));
    // R8
    sticky_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_det) |-> $past(clr));
    // R9
    rst_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_req |-> (st_rst && st_det));
    // R9
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_req |=> !core_rst_req || $past(samp && cmp_below));
endmodule

// File: rtl/supmon_ctrl.sv
// Top of the duty-cycled supply monitor controller. Ties the register port,
// window generator and sampler together and forms the interrupt level.
// Assumes every input is synchronous to clk (the slow clock).
module supmon_ctrl
    import supmon_pkg::*;
#(
    parameter int PER_A = 32,
    parameter int PER_B = 256,
    parameter int PER_C = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             cmp_below,
    output logic [THR_W-1:0] mon_thresh,
    output logic             mon_en,
    output logic             irq,
    output logic             core_rst_req
);
    mode_t mode;
    logic  smpl_chg;
    logic  stat_clr;
    logic  st_rst;
    logic  st_det;
    logic  st_live;

    supmon_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .st_rst(st_rst), .st_det(st_det), .st_live(st_live),
        .mode(mode), .smpl_chg(smpl_chg), .stat_clr(stat_clr), .rdata(reg_rdata)
    );

    supmon_window #(.PER_A(PER_A), .PER_B(PER_B), .PER_C(PER_C)) u_window (
        .clk(clk), .rst_n(rst_n), .smpl(mode.smpl), .restart(smpl_chg),
        .mon_en(mon_en)
    );

    supmon_sampler u_sampler (
        .clk(clk), .rst_n(rst_n), .samp(mon_en), .cmp_below(cmp_below),
        .rsten(mode.rsten), .clr(stat_clr), .live(st_live), .st_det(st_det),
        .st_rst(st_rst), .core_rst_req(core_rst_req)
    );

    assign mon_thresh = mode.thr;
    assign irq        = st_det && mode.ien;

    // R10
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> st_det);
    // R10
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode.ien |-> !irq);
endmodule

// File: tb/supmon_ctrl_tb.sv
module supmon_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0, cmp_below = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  mon_thresh;
    logic        mon_en, irq, core_rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    supmon_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmp_below(cmp_below), .mon_thresh(mon_thresh), .mon_en(mon_en),
        .irq(irq), .core_rst_req(core_rst_req)
    );

    // Reference model state, written from the requirements.
    logic [3:0]  m_thr;
    logic [2:0]  m_smpl;
    logic        m_rsten, m_ien, m_live, m_sdet, m_srst, m_crst;
    int          m_cnt;
    logic [31:0] m_rdata;

    function automatic int per_of(logic [2:0] s);
        case (s)
            3'd2: return 32;
            3'd3: return 256;
            3'd4: return 2048;
            default: return 0;
        endcase
    endfunction

    function automatic logic exp_en();
        return (m_smpl == 3'd1) || (per_of(m_smpl) != 0 && m_cnt == per_of(m_smpl) - 1);
    endfunction

    function automatic logic [31:0] mode_word();
        logic [31:0] w = '0;
        w[3:0] = m_thr; w[10:8] = m_smpl; w[12] = m_rsten; w[13] = m_ien;
        return w;
    endfunction

    function automatic logic [31:0] stat_word();
        logic [31:0] w = '0;
        w[4] = m_srst; w[5] = m_sdet; w[6] = m_live;
        return w;
    endfunction

    always @(posedge clk) begin : model
        logic samp, det, clr;
        if (!rst_n) begin
            m_thr <= '0; m_smpl <= '0; m_rsten <= 0; m_ien <= 0; m_live <= 0;
            m_sdet <= 0; m_srst <= 0; m_crst <= 0; m_cnt <= 0; m_rdata <= '0;
        end else begin
            samp = exp_en();
            det  = samp && cmp_below;
            clr  = reg_rd && reg_addr;
            if (reg_rd) m_rdata <= reg_addr ? stat_word() : mode_word();
            m_crst <= det && m_rsten;
            m_sdet <= (m_sdet && !clr) || det;
            m_srst <= (m_srst && !clr) || (det && m_rsten);
            if (samp) m_live <= cmp_below;
            if (reg_wr && !reg_addr && reg_wdata[10:8] != m_smpl) m_cnt <= 0;
            else if (per_of(m_smpl) != 0) m_cnt <= (m_cnt == per_of(m_smpl) - 1) ? 0 : m_cnt + 1;
            else m_cnt <= 0;
            if (reg_wr && !reg_addr) begin
                m_thr <= reg_wdata[3:0]; m_smpl <= reg_wdata[10:8];
                m_rsten <= reg_wdata[12]; m_ien <= reg_wdata[13];
            end
        end
    end

    task automatic expect_eq(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock cycle with the given inputs, then lockstep comparison.
    task automatic cyc(logic wr, logic rd, logic addr, logic [31:0] wd, logic cmp);
        reg_wr = wr; reg_rd = rd; reg_addr = addr; reg_wdata = wd; cmp_below = cmp;
        @(negedge clk);
        expect_eq("R5 mon_en", {31'd0, mon_en}, {31'd0, exp_en()});
        expect_eq("R10 irq", {31'd0, irq}, {31'd0, m_sdet && m_ien});
        expect_eq("R9 core_rst_req", {31'd0, core_rst_req}, {31'd0, m_crst});
        expect_eq("R2 mon_thresh", {28'd0, mon_thresh}, {28'd0, m_thr});
        expect_eq("R8 rdata", reg_rdata, m_rdata);
    endtask

    function automatic logic [31:0] mw(int thr, int smpl, bit rsten, bit ien);
        logic [31:0] w = '0;
        w[3:0] = 4'(thr); w[10:8] = 3'(smpl); w[12] = rsten; w[13] = ien;
        return w;
    endfunction

    task automatic idle(int n, logic cmp);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, '0, cmp);
    endtask

    task automatic measure_gap(string req, int exp);
        int n = 0;
        while (!mon_en && n < 5000) begin cyc(0, 0, 0, '0, 0); n++; end
        expect_eq(req, n, exp);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        expect_eq("R1 outputs", {mon_en, irq, core_rst_req, mon_thresh}, '0);
        expect_eq("R1 rdata", reg_rdata, '0);
        rst_n = 1'b1;
        cyc(0, 1, 1, '0, 0);
        expect_eq("R1 status read", reg_rdata, '0);
        cyc(0, 1, 0, '0, 0);
        expect_eq("R1 mode read", reg_rdata, '0);

        // R2: field store, readback, junk bits ignored
        cyc(1, 0, 0, mw(10, 1, 1, 1) | 32'hFFC0_08F0, 0);
        cyc(0, 1, 0, '0, 0);
        expect_eq("R2 readback", reg_rdata, 32'h0000_310A);
        expect_eq("R2 thresh", {28'd0, mon_thresh}, 32'hA);

        // R4: continuous mode samples every edge; R7 live follows
        expect_eq("R4 mon_en", {31'd0, mon_en}, 1);
        cyc(0, 0, 0, '0, 1);
        cyc(0, 1, 1, '0, 0);
        expect_eq("R7 live after below", reg_rdata[6], 1);
        expect_eq("R9 reset flag", reg_rdata[4], 1);
        cyc(0, 1, 1, '0, 0);
        expect_eq("R4 live after above", reg_rdata[6], 0);
        expect_eq("R8 cleared", reg_rdata[5], 0);

        // R8: detection on the same edge as a clearing read
        cyc(0, 0, 0, '0, 1);
        cyc(0, 1, 1, '0, 1);
        expect_eq("R8 pre-clear value", reg_rdata[5], 1);
        cyc(0, 1, 1, '0, 0);
        expect_eq("R8 detection wins", reg_rdata[5], 1);
        cyc(0, 1, 1, '0, 0);
        expect_eq("R8 now clear", reg_rdata[5], 0);

        // R9: reset disabled -> no pulse, no reset flag; R10 irq masked
        cyc(1, 0, 0, mw(3, 1, 0, 0), 0);
        cyc(0, 0, 0, '0, 1);
        expect_eq("R9 no pulse", {31'd0, core_rst_req}, 0);
        expect_eq("R10 masked", {31'd0, irq}, 0);
        cyc(0, 1, 1, '0, 0);
        expect_eq("R9 no flag", reg_rdata[6:4], 3'b110);

        // R3: disabled and unused codes leave live untouched
        cyc(1, 0, 0, mw(3, 1, 0, 1), 1);
        cyc(1, 0, 0, mw(3, 0, 0, 1), 1);
        idle(40, 0);
        expect_eq("R3 mode0 idle", {31'd0, mon_en}, 0);
        cyc(0, 1, 1, '0, 0);
        expect_eq("R3 live held", reg_rdata[6], 1);
        cyc(1, 0, 0, mw(3, 6, 0, 1), 0);
        idle(40, 0);
        cyc(0, 1, 1, '0, 0);
        expect_eq("R3 code6 live held", reg_rdata[6], 1);

        // R5: window spacing for each duty mode
        cyc(1, 0, 0, mw(5, 2, 1, 1), 0);
        measure_gap("R5 first window A", 31);
        cyc(0, 0, 0, '0, 0);
        measure_gap("R5 period A", 31);
        cyc(1, 0, 0, mw(5, 4, 1, 1), 0);
        measure_gap("R5 first window C", 2047);

        // R6: changing mode restarts, same mode does not
        cyc(1, 0, 0, mw(5, 2, 1, 1), 0);
        idle(10, 0);
        cyc(1, 0, 0, mw(5, 3, 1, 1), 0);
        measure_gap("R6 restart on change", 255);
        cyc(1, 0, 0, mw(5, 2, 1, 1), 0);
        idle(10, 0);
        cyc(1, 0, 0, mw(7, 2, 1, 1), 0);
        measure_gap("R6 no restart on same", 20);

        // Random traffic checked in lockstep against the model.
        for (int i = 0; i < 30000; i++) begin
            logic wr, rd;
            logic [31:0] wd;
            wr = ($urandom % 64) == 0;
            rd = ($urandom % 4) == 0;
            wd = $urandom;
            wd[10:8] = (($urandom % 8) < 6) ? 3'($urandom % 5) : 3'($urandom);
            cyc(wr, rd, 1'($urandom), wd, 1'($urandom));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule